// File: doc/BRIEF.md
# Received-Word Repeater Path

This block sits between the receive holding register of a serial-word bridge and its transmit queue. A received 32-bit word is latched into a holding register. The host reads that word over a 16-bit bus in two halves, and a half-select input picks which half appears. In normal mode the host may take the halves in either order, and nothing is queued for transmission.

In repeater mode, every half the host reads is also captured for the transmit queue. This lets a received word go back out on the line without the host writing it again. The lower half has to be read first. It is staged, and the whole word enters the transmit FIFO only when the upper half is read, so the transmit side never sees a half-built entry. An upper-half read with no staged lower half for the same word is not queued, and it raises a sticky sequence-error flag.

The transmit FIFO has eight entries and shows empty and full flags. A word that completes while the FIFO is full is dropped, and this raises a sticky overflow flag. A master-reset input aborts activity: it clears the FIFO, the flags and the holding-register state, but leaves the configured mode untouched. The synchronous system reset also returns the mode to normal.

Top module: `rx_repeater_bridge`

## Requirements
- R1: A one-cycle pulse on `rx_valid` latches `rx_word`, and `rx_ready` reads 1 after that clock edge. While the word is held, `rd_data` shows bits 15:0 when `rd_sel`=0 and bits 31:16 when `rd_sel`=1.
- R2: In normal mode (`mode_repeat`=0), the halves can be read in either order. `rx_ready` stays 1 after the first half is read and goes to 0 after the edge on which the second half is read. Normal-mode reads never put anything into the FIFO.
- R3: In repeater mode (`mode_repeat`=1), a lower-half read followed by an upper-half read of the same word queues one entry whose value is {upper, lower}. The entry is committed on the upper-half read edge, so `tx_empty` stays 1 after the lower-half read alone.
- R4: In repeater mode, an upper-half read with no staged lower half queues nothing and sets `seq_err`, which then stays 1 until a reset. A lower half staged for an earlier word does not count once a new word has been latched.
- R5: The FIFO holds 8 words and returns them in arrival order on `tx_word`. `tx_full` is 1 when it holds 8 words, and `tx_empty` is 1 when it holds none. A `tx_pop` pulse removes the entry at the head.
- R6: A completed word that arrives while the FIFO is full is dropped. It sets the sticky `tx_ovf` flag and leaves the stored entries and their order unchanged.
- R7: A `mreset` pulse leaves the FIFO empty, and `tx_full`, `rx_ready`, `seq_err` and `tx_ovf` at 0, after its clock edge.
- R8: The mode written through `cfg_we`/`cfg_repeat` is kept through `mreset`. `rst` returns it to normal.
- R9: A `tx_pop` while the FIFO is empty is ignored, and later pushes and pops behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; clears everything, including the mode |
| mreset | input | 1 | Master reset; clears the FIFO, flags and holding state, but keeps the mode |
| cfg_we | input | 1 | Mode write strobe |
| cfg_repeat | input | 1 | Mode value to write: 1 is repeater, 0 is normal |
| mode_repeat | output | 1 | Current mode |
| rx_valid | input | 1 | Pulse that latches a newly received word |
| rx_word | input | 32 | Received word |
| rx_ready | output | 1 | A word is held that has not yet had both halves read |
| rd_en | input | 1 | Host read strobe for one half |
| rd_sel | input | 1 | Half select: 0 for lower, 1 for upper |
| rd_data | output | 16 | Selected half of the held word |
| seq_err | output | 1 | Sticky repeater read-order error |
| tx_pop | input | 1 | Removes the head entry of the FIFO |
| tx_word | output | 32 | Head entry of the FIFO |
| tx_empty | output | 1 | FIFO empty |
| tx_full | output | 1 | FIFO full |
| tx_ovf | output | 1 | Sticky flag: a word was dropped because the FIFO was full |

## Verification
The hardest case to reach from the ports is a word that completes in repeater mode while the FIFO already holds eight entries. Reaching it takes eight full receive-and-read cycles with no pops, and only then a ninth word. The bench then drains the FIFO entry by entry, which shows that the dropped word left no trace and that the order was kept. A second hard case is a stale staged lower half: the bench stages the lower half of one word, latches a new word and reads only its upper half, which must not produce a queued entry.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int TXQ_DEPTH = 8;

    typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} half_sel_e;
    typedef enum logic {MODE_NORMAL = 1'b0, MODE_REPEAT = 1'b1} rpt_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } word_t;

    function automatic word_t join_halves(logic [HALF_W-1:0] hi, logic [HALF_W-1:0] lo);
        word_t w;
        w.hi = hi;
        w.lo = lo;
        return w;
    endfunction
endpackage

// File: rtl/rx_hold.sv
module rx_hold
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mreset,
    input  logic              load,
    input  word_t             word_in,
    input  logic              rd_en,
    input  half_sel_e         rd_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              ready
);
    word_t word_q;
    logic  lo_done, hi_done;
    logic  lo_next, hi_next;

    assign rd_data = (rd_sel == SEL_HI) ? word_q.hi : word_q.lo;
    assign lo_next = lo_done | (rd_en && rd_sel == SEL_LO);
    assign hi_next = hi_done | (rd_en && rd_sel == SEL_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            ready   <= 1'b0;
            lo_done <= 1'b0;
            hi_done <= 1'b0;
        end else if (mreset) begin
            ready   <= 1'b0;
            lo_done <= 1'b0;
            hi_done <= 1'b0;
        end else if (load) begin
            word_q  <= word_in;
            ready   <= 1'b1;
            lo_done <= 1'b0;
            hi_done <= 1'b0;
        end else if (rd_en) begin
            lo_done <= lo_next;
            hi_done <= hi_next;
            if (lo_next && hi_next) ready <= 1'b0;
        end
    end

    // R1: a latched word is flagged ready
    p_ready_on_load_r1: assert property (@(posedge clk) disable iff (rst)
        (load && !mreset) |=> ready);
    // R2: ready cannot survive a read that completes both halves
    p_ready_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !load && !mreset && lo_next && hi_next) |=> !ready);
endmodule

// File: rtl/tx_assembler.sv
module tx_assembler
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mreset,
    input  rpt_mode_e         mode,
    input  logic              new_word,
    input  logic              rd_en,
    input  half_sel_e         rd_sel,
    input  logic [HALF_W-1:0] rd_data,
    output logic              push,
    output word_t             push_word,
    output logic              seq_err
);
    logic [HALF_W-1:0] lo_q;
    logic              lo_valid;
    logic              rpt_rd;

    assign rpt_rd    = rd_en && (mode == MODE_REPEAT) && !mreset && !new_word;
    assign push      = rpt_rd && (rd_sel == SEL_HI) && lo_valid;
    assign push_word = join_halves(rd_data, lo_q);

    always_ff @(posedge clk) begin
        if (rst || mreset) begin
            lo_q     <= '0;
            lo_valid <= 1'b0;
            seq_err  <= 1'b0;
        end else if (new_word) begin
            lo_valid <= 1'b0;
        end else if (rpt_rd) begin
            if (rd_sel == SEL_LO) begin
                lo_q     <= rd_data;
                lo_valid <= 1'b1;
            end else if (lo_valid) begin
                lo_valid <= 1'b0;
            end else begin
                seq_err  <= 1'b1;
            end
        end
    end

    // R4: an orphan upper-half read raises the error flag
    p_orphan_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (rpt_rd && rd_sel == SEL_HI && !lo_valid) |=> seq_err);
    // R4: the error flag is sticky until a reset
    p_seq_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (seq_err && !mreset) |=> seq_err);
    // R3: a staged lower half is consumed by its upper half
    p_stage_consumed_r3: assert property (@(posedge clk) disable iff (rst)
        push |=> !lo_valid);
endmodule

// File: rtl/tx_word_fifo.sv
module tx_word_fifo
    import rptr_pkg::*;
#(
    parameter int DEPTH = TXQ_DEPTH
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  mreset,
    input  logic  push,
    input  word_t push_word,
    input  logic  pop,
    output word_t head,
    output logic  empty,
    output logic  full,
    output logic  ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push && !mreset) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst || mreset) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push && full) ovf <= 1'b1;
        end
    end

    // R5: flags never both set, occupancy within depth
    p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R6: drop when full raises overflow and keeps the FIFO full
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !mreset) |=> (ovf && full));
    // R7: master reset empties the queue and clears overflow
    p_mreset_clears_r7: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (empty && !ovf));
    // R9: a pop on empty leaves it empty when nothing is pushed
    p_pop_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/rx_repeater_bridge.sv
module rx_repeater_bridge
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mreset,
    input  logic              cfg_we,
    input  logic              cfg_repeat,
    output logic              mode_repeat,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic              rx_ready,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              seq_err,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_word,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              tx_ovf
);
    rpt_mode_e mode_q;
    half_sel_e sel;
    logic      push;
    word_t     push_word, head;

    assign sel         = half_sel_e'(rd_sel);
    assign mode_repeat = (mode_q == MODE_REPEAT);
    assign tx_word     = head;

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= MODE_NORMAL;
        else if (cfg_we) mode_q <= rpt_mode_e'(cfg_repeat);
    end

    rx_hold u_hold (
        .clk(clk), .rst(rst), .mreset(mreset), .load(rx_valid),
        .word_in(word_t'(rx_word)), .rd_en(rd_en), .rd_sel(sel),
        .rd_data(rd_data), .ready(rx_ready)
    );

    tx_assembler u_asm (
        .clk(clk), .rst(rst), .mreset(mreset), .mode(mode_q),
        .new_word(rx_valid), .rd_en(rd_en), .rd_sel(sel), .rd_data(rd_data),
        .push(push), .push_word(push_word), .seq_err(seq_err)
    );

    tx_word_fifo #(.DEPTH(TXQ_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .mreset(mreset), .push(push),
        .push_word(push_word), .pop(tx_pop), .head(head),
        .empty(tx_empty), .full(tx_full), .ovf(tx_ovf)
    );

    // R8: master reset leaves the mode alone
    p_mode_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (mreset && !cfg_we) |=> $stable(mode_q));
    // R2: normal-mode reads never queue anything
    p_normal_no_push_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL && tx_empty && !rx_valid) |=> tx_empty);
endmodule

// File: tb/sim_rx_repeater_bridge.sv
module sim_rx_repeater_bridge;
    logic        clk = 1'b0;
    logic        rst, mreset, cfg_we, cfg_repeat, rx_valid, rd_en, rd_sel, tx_pop;
    logic [31:0] rx_word;
    logic        mode_repeat, rx_ready, seq_err, tx_empty, tx_full, tx_ovf;
    logic [15:0] rd_data;
    logic [31:0] tx_word;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    rx_repeater_bridge u0 (
        .clk(clk), .rst(rst), .mreset(mreset), .cfg_we(cfg_we), .cfg_repeat(cfg_repeat),
        .mode_repeat(mode_repeat), .rx_valid(rx_valid), .rx_word(rx_word),
        .rx_ready(rx_ready), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .seq_err(seq_err), .tx_pop(tx_pop), .tx_word(tx_word), .tx_empty(tx_empty),
        .tx_full(tx_full), .tx_ovf(tx_ovf)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        rst = 0; mreset = 0; cfg_we = 0; cfg_repeat = 0; rx_valid = 0;
        rd_en = 0; rd_sel = 0; tx_pop = 0; rx_word = '0;
    endtask

    task automatic do_rst();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    task automatic do_mrst();
        @(negedge clk); mreset = 1;
        @(negedge clk); mreset = 0;
    endtask

    task automatic set_mode(bit rep);
        @(negedge clk); cfg_we = 1; cfg_repeat = rep;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic load(logic [31:0] w);
        @(negedge clk); rx_valid = 1; rx_word = w;
        @(negedge clk); rx_valid = 0;
    endtask

    task automatic rd(bit s, output logic [15:0] d);
        @(negedge clk); rd_en = 1; rd_sel = s;
        #1 d = rd_data;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic pop1();
        @(negedge clk); tx_pop = 1;
        @(negedge clk); tx_pop = 0;
    endtask

    task automatic repeat_word(logic [31:0] w);
        logic [15:0] d;
        load(w);
        rd(0, d);
        rd(1, d);
    endtask

    task automatic t_reset();
        do_rst();
        chk("R7 reset rx_ready", rx_ready, 0);
        chk("R5 reset tx_empty", tx_empty, 1);
        chk("R5 reset tx_full", tx_full, 0);
        chk("R4 reset seq_err", seq_err, 0);
        chk("R6 reset tx_ovf", tx_ovf, 0);
        chk("R8 reset mode normal", mode_repeat, 0);
    endtask

    task automatic t_normal();
        logic [15:0] d;
        load(32'hA5A5_1234);
        chk("R1 ready after load", rx_ready, 1);
        rd(1, d);
        chk("R1 upper half", d, 16'hA5A5);
        chk("R2 ready after one half", rx_ready, 1);
        rd(0, d);
        chk("R1 lower half", d, 16'h1234);
        chk("R2 ready cleared", rx_ready, 0);
        chk("R2 nothing queued", tx_empty, 1);
    endtask

    task automatic t_repeat_basic();
        logic [15:0] d;
        set_mode(1);
        chk("R8 mode set", mode_repeat, 1);
        load(32'hDEAD_BEEF);
        rd(0, d);
        chk("R3 empty after lower only", tx_empty, 1);
        rd(1, d);
        chk("R3 entry queued", tx_empty, 0);
        chk("R3 entry value", tx_word, 32'hDEAD_BEEF);
        chk("R2 ready cleared in repeat", rx_ready, 0);
        pop1();
        chk("R5 empty after pop", tx_empty, 1);
    endtask

    task automatic t_seq();
        logic [15:0] d;
        load(32'h1111_2222);
        rd(1, d);
        chk("R4 orphan upper not queued", tx_empty, 1);
        chk("R4 seq_err set", seq_err, 1);
        repeat_word(32'h3333_4444);
        chk("R4 seq_err sticky", seq_err, 1);
        chk("R3 good pair after error", tx_word, 32'h3333_4444);
        do_mrst();
        chk("R7 seq_err cleared", seq_err, 0);
        chk("R7 fifo cleared", tx_empty, 1);
        load(32'h5555_6666);
        rd(0, d);
        load(32'h7777_8888);
        rd(1, d);
        chk("R4 stale lower not used", tx_empty, 1);
        chk("R4 stale lower error", seq_err, 1);
        do_mrst();
    endtask

    task automatic t_fill();
        for (int i = 0; i < 8; i++) repeat_word(32'h0100_0000 * (i + 1) + i);
        chk("R5 full at 8", tx_full, 1);
        chk("R6 no ovf yet", tx_ovf, 0);
        repeat_word(32'hFFFF_FFFF);
        chk("R6 ovf set", tx_ovf, 1);
        chk("R6 still full", tx_full, 1);
        for (int i = 0; i < 8; i++) begin
            chk("R5 order / R6 drop", tx_word, 32'h0100_0000 * (i + 1) + i);
            pop1();
        end
        chk("R5 empty after drain", tx_empty, 1);
        chk("R6 ovf sticky", tx_ovf, 1);
        pop1();
        chk("R9 pop on empty", tx_empty, 1);
        repeat_word(32'hCAFE_0001);
        chk("R9 push after empty pop", tx_word, 32'hCAFE_0001);
        pop1();
        chk("R9 single pop empties", tx_empty, 1);
    endtask

    task automatic t_mreset_mode();
        logic [15:0] d;
        repeat_word(32'h0A0A_0B0B);
        repeat_word(32'h0C0C_0D0D);
        load(32'h1234_5678);
        do_mrst();
        chk("R7 empty after mreset", tx_empty, 1);
        chk("R7 ready cleared", rx_ready, 0);
        chk("R7 ovf cleared", tx_ovf, 0);
        chk("R8 mode kept", mode_repeat, 1);
        repeat_word(32'h9999_AAAA);
        chk("R8 still repeating", tx_word, 32'h9999_AAAA);
        do_rst();
        chk("R8 rst clears mode", mode_repeat, 0);
        load(32'hBBBB_CCCC);
        rd(0, d);
        rd(1, d);
        chk("R8 normal after rst", tx_empty, 1);
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_normal();
        t_repeat_basic();
        t_seq();
        t_fill();
        t_mreset_mode();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule